// File: doc/BRIEF.md
# GPIO Bank Write-Lock Sequencer

This block protects the configuration and output registers of one 32-pin GPIO bank against stray software writes. It watches every write on the bank's register bus. It keeps the bank in one of three states: open, locked, or locked with the first unlock key accepted. Any register bank that shares the same bus can use its write-inhibit output to drop writes to protected registers for as long as the bank is locked.

Locking is cheap: one write of zero to either lock register does it. Unlocking is deliberately awkward. Software must write a first 32-bit key, 0xC0DE1248, to the second lock register (word 17). The very next bus write must then put a second key, 0xC0DEFA73, into the first lock register (word 16). A read of the first lock register returns the lock state in bit 0.

Top module: `gpio_wlock_seq`

## Requirements
- R1: After a synchronous reset the bank is open: `locked` = 0, `key_armed` = 0 and `rd_data` = 0.
- R2: A write of 32'h0 to word 16 while open sets `locked` from the following cycle.
- R3: A write of 32'h0 to word 17 while open sets `locked` from the following cycle.
- R4: While open, a nonzero write to word 16 or word 17 leaves the bank open and not armed. This includes the first key written to word 17.
- R5: A read (`rd_en` high) of word 16 returns {31'b0, lock state before the read edge} on `rd_data` one cycle later. A read of any other word, or no read, returns 0.
- R6: `wr_inhibit` is high in the same cycle as a write while the bank is locked or armed, but only when the write targets a protected word (words 0 to 15 by default). It is never high for writes to words 16 or 17, for writes to unprotected words, or while the bank is open.
- R7: While locked and not armed, a write of 32'hC0DE1248 to word 17 sets `key_armed` from the next cycle. `locked` stays high.
- R8: While armed, a write of 32'hC0DEFA73 to word 16 opens the bank from the next cycle: `locked` = 0 and `key_armed` = 0.
- R9: While armed, any other write (other word, other value, or the first key again) clears `key_armed` and keeps `locked` high. While locked and not armed, the second key written to word 16 has no effect.
- R10: The two keys only unlock the bank in the order first key then second key. The second key written before the first key leaves the bank locked.
- R11: Cycles without a write leave `locked` and `key_armed` unchanged, so an armed bank stays armed across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Word index of the read |
| rd_data | output | 32 | Registered read data for the lock status word |
| wr_inhibit | output | 1 | Drop the current write to a protected register |
| locked | output | 1 | Bank is locked (including armed) |
| key_armed | output | 1 | First unlock key accepted, second expected next |

## Verification
The sequencer is driven with several kinds of write streams, and each one separates a different set of faults:
- Zero and nonzero values sent to each lock word separate the lock command from the keys.
- The keys are sent in order, in reverse order, with an interloping write, and with idle gaps. These separate a proper two-step unlock from a one-step unlock, from an unlock in either order, and from a pending state that fails to clear or that decays on its own.
- Writes to protected, lock and unprotected words in every state test the inhibit decode.
- A long random stream that favours the lock words and the key values cross-checks every state against a bench model.

// File: rtl/gwl_pkg.sv
package gwl_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hC0DE_1248;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'hC0DE_FA73;

  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_SHUT  = 2'd1,
    ST_ARMED = 2'd2
  } lock_state_t;

  typedef struct packed {
    logic wr;       // any bank write this cycle
    logic hit_a;    // write to first lock word
    logic hit_b;    // write to second lock word
    logic prot;     // write to a protected word
    logic zero;     // write data is zero
    logic key1;     // write data equals first key
    logic key2;     // write data equals second key
  } wr_decode_t;
endpackage

// File: rtl/gwl_decode.sv
module gwl_decode
  import gwl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LOCK_A_IDX = 16,
  parameter int LOCK_B_IDX = 17,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = 'hFFFF
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_decode_t        dec
);
  localparam int NWORDS = 1 << ADDR_W;
  localparam logic [NWORDS-1:0] LOCK_BITS =
    (NWORDS'(1) << LOCK_A_IDX) | (NWORDS'(1) << LOCK_B_IDX);
  localparam logic [NWORDS-1:0] EFF_MASK = PROT_MASK & ~LOCK_BITS;

  logic [NWORDS-1:0] sel;

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_sel
      assign sel[w] = (wr_addr == ADDR_W'(w));
    end
  endgenerate

  always_comb begin
    dec.wr    = wr_en;
    dec.hit_a = wr_en && sel[LOCK_A_IDX];
    dec.hit_b = wr_en && sel[LOCK_B_IDX];
    dec.prot  = wr_en && (|(sel & EFF_MASK));
    dec.zero  = (wr_data == '0);
    dec.key1  = (wr_data == KEY_FIRST);
    dec.key2  = (wr_data == KEY_SECOND);
  end
endmodule

// File: rtl/gwl_fsm.sv
module gwl_fsm
  import gwl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wr_decode_t dec,
  output logic       locked,
  output logic       key_armed
);
  lock_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN: begin
        if ((dec.hit_a || dec.hit_b) && dec.zero) state_d = ST_SHUT;
      end
      ST_SHUT: begin
        if (dec.hit_b && dec.key1) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (dec.hit_a && dec.key2) state_d = ST_OPEN;
        else if (dec.wr)           state_d = ST_SHUT;
      end
      default: state_d = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OPEN;
      locked    <= 1'b0;
      key_armed <= 1'b0;
    end else begin
      state_q   <= state_d;
      locked    <= (state_d != ST_OPEN);
      key_armed <= (state_d == ST_ARMED);
    end
  end
endmodule

// File: rtl/gwl_readback.sv
module gwl_readback
  import gwl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LOCK_A_IDX = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              locked,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en && (rd_addr == ADDR_W'(LOCK_A_IDX))) begin
      rd_data <= {{(DATA_W-1){1'b0}}, locked};
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/gpio_wlock_seq.sv
module gpio_wlock_seq
  import gwl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LOCK_A_IDX = 16,
  parameter int LOCK_B_IDX = 17,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = 'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              wr_inhibit,
  output logic              locked,
  output logic              key_armed
);
  wr_decode_t dec;

  gwl_decode #(
    .ADDR_W(ADDR_W), .LOCK_A_IDX(LOCK_A_IDX),
    .LOCK_B_IDX(LOCK_B_IDX), .PROT_MASK(PROT_MASK)
  ) i_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dec(dec)
  );

  gwl_fsm i_fsm (
    .clk(clk), .rst(rst), .dec(dec),
    .locked(locked), .key_armed(key_armed)
  );

  gwl_readback #(.ADDR_W(ADDR_W), .LOCK_A_IDX(LOCK_A_IDX)) i_readback (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .locked(locked), .rd_data(rd_data)
  );

  // Same-cycle gate: the register bank commits on this very edge.
  assign wr_inhibit = dec.prot && locked;
endmodule

// File: rtl/gwl_checker.sv
module gwl_checker
  import gwl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LOCK_A_IDX = 16,
  parameter int LOCK_B_IDX = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_inhibit,
  input logic              locked,
  input logic              key_armed
);
  logic to_a, to_b;
  assign to_a = wr_en && (wr_addr == ADDR_W'(LOCK_A_IDX));
  assign to_b = wr_en && (wr_addr == ADDR_W'(LOCK_B_IDX));

  p_lock_a_r2: assert property (@(posedge clk) disable iff (rst)
    (!locked && to_a && wr_data == 32'h0) |=> locked)
    else $error("p_lock_a_r2");

  p_lock_b_r3: assert property (@(posedge clk) disable iff (rst)
    (!locked && to_b && wr_data == 32'h0) |=> locked)
    else $error("p_lock_b_r3");

  p_inhibit_locked_r6: assert property (@(posedge clk) disable iff (rst)
    wr_inhibit |-> (locked && wr_en))
    else $error("p_inhibit_locked_r6");

  p_lockreg_free_r6: assert property (@(posedge clk) disable iff (rst)
    (to_a || to_b) |-> !wr_inhibit)
    else $error("p_lockreg_free_r6");

  p_arm_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && !key_armed && to_b && wr_data == KEY_FIRST) |=> (key_armed && locked))
    else $error("p_arm_r7");

  p_unlock_r8: assert property (@(posedge clk) disable iff (rst)
    (key_armed && to_a && wr_data == KEY_SECOND) |=> (!locked && !key_armed))
    else $error("p_unlock_r8");

  p_armed_is_locked_r9: assert property (@(posedge clk) disable iff (rst)
    key_armed |-> locked)
    else $error("p_armed_is_locked_r9");

  p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
    (key_armed && wr_en && !(to_a && wr_data == KEY_SECOND)) |=> (locked && !key_armed))
    else $error("p_disarm_r9");

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(locked) && $stable(key_armed)))
    else $error("p_hold_r11");
endmodule

bind gpio_wlock_seq gwl_checker #(
  .ADDR_W(ADDR_W), .LOCK_A_IDX(LOCK_A_IDX), .LOCK_B_IDX(LOCK_B_IDX)
) i_gwl_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_inhibit(wr_inhibit), .locked(locked), .key_armed(key_armed)
);

// File: tb/test_gpio_wlock_seq.sv
module test_gpio_wlock_seq;
  localparam int AW = 6;
  localparam logic [31:0] K1 = 32'hC0DE_1248;
  localparam logic [31:0] K2 = 32'hC0DE_FA73;
  localparam int LA = 16;
  localparam int LB = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic wr_inhibit, locked, key_armed;

  int n_chk = 0;
  int n_bad = 0;
  int st = 0; // model: 0 open, 1 locked, 2 armed

  always #5 clk = ~clk;

  gpio_wlock_seq i_gpio_wlock_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_inhibit(wr_inhibit), .locked(locked), .key_armed(key_armed)
  );

  function automatic int model_next(int s, logic we, int a, logic [31:0] d);
    if (!we) return s;
    case (s)
      0: return ((a == LA || a == LB) && d == 32'h0) ? 1 : 0;
      1: return (a == LB && d == K1) ? 2 : 1;
      default: return (a == LA && d == K2) ? 0 : 1;
    endcase
  endfunction

  function automatic logic model_inhibit(int s, logic we, int a);
    return we && (s != 0) && (a < 16);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, int a, logic [31:0] d, logic re, int ra);
    int pre;
    @(negedge clk);
    wr_en = we; wr_addr = AW'(a); wr_data = d;
    rd_en = re; rd_addr = AW'(ra);
    #1;
    chk({tag, " R6 inhibit"}, 32'(wr_inhibit), 32'(model_inhibit(st, we, a)));
    pre = st;
    @(posedge clk);
    #1;
    st = model_next(st, we, a, d);
    chk({tag, " locked"}, 32'(locked), 32'(st != 0));
    chk({tag, " key_armed"}, 32'(key_armed), 32'(st == 2));
    chk({tag, " R5 readback"}, rd_data, (re && ra == LA) ? 32'(pre != 0) : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset locked", 32'(locked), 32'h0);
    chk("R1 reset armed", 32'(key_armed), 32'h0);
    chk("R1 reset rd_data", rd_data, 32'h0);

    step("R6 open write", 1, 0, 32'h1234, 0, 0);
    step("R4 nonzero lockA", 1, LA, 32'h5, 0, 0);
    step("R4 nonzero lockB", 1, LB, 32'h1, 0, 0);
    step("R4 key1 while open", 1, LB, K1, 0, 0);
    step("R5 read open", 0, 0, 0, 1, LA);
    step("R2 zero to lockA", 1, LA, 32'h0, 0, 0);
    step("R5 read locked", 0, 0, 0, 1, LA);
    step("R5 read other word", 0, 0, 0, 1, LB);
    step("R6 protected write locked", 1, 0, 32'hFFFF, 0, 0);
    step("R6 lock word write locked", 1, LA, 32'h7, 0, 0);
    step("R6 unprotected write locked", 1, 20, 32'h9, 0, 0);
    step("R9 key2 unarmed", 1, LA, K2, 0, 0);
    step("R7 key1 arms", 1, LB, K1, 0, 0);
    step("R9 interloper", 1, 3, 32'h0, 0, 0);
    step("R7 re-arm", 1, LB, K1, 0, 0);
    step("R11 idle", 0, 0, 0, 0, 0);
    step("R11 idle", 0, 0, 0, 0, 0);
    step("R8 key2 unlocks", 1, LA, K2, 0, 0);
    step("R6 open after unlock", 1, 0, 32'h1, 1, LA);
    step("R3 zero to lockB", 1, LB, 32'h0, 0, 0);
    step("R10 key2 first", 1, LA, K2, 0, 0);
    step("R10 key1 second", 1, LB, K1, 0, 0);
    step("R9 wrong second key", 1, LA, 32'h1234, 0, 0);
    step("R7 arm again", 1, LB, K1, 0, 0);
    step("R9 key1 twice", 1, LB, K1, 0, 0);
    step("R7 arm", 1, LB, K1, 0, 0);
    step("R8 unlock", 1, LA, K2, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int a, ra, pick;
      logic [31:0] d;
      logic we, re;
      pick = int'($urandom_range(0, 9));
      a = (pick < 4) ? LB : (pick < 7) ? LA : (pick < 9) ? int'($urandom_range(0, 19)) : 40;
      pick = int'($urandom_range(0, 9));
      d = (pick < 3) ? 32'h0 : (pick < 6) ? K1 : (pick < 8) ? K2 : $urandom;
      we = ($urandom_range(0, 4) != 0);
      re = $urandom_range(0, 1) != 0;
      ra = ($urandom_range(0, 1) != 0) ? LA : int'($urandom_range(0, 63));
      step("R2 R3 R4 R7 R8 R9 R10 R11 random", we, a, d, re, ra);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule